// File: doc/BRIEF.md
# Bus Slave Interface with Ready Extension

This block sits on the slave side of a strobe-based parallel bus. An address window is fixed by parameters. The block decodes each address combinationally against that window. The decode is qualified by the memory/IO line and the above-16M qualifier line. When the address hits, the block drives its select-feedback and data-size replies straight back to the master, with no clock in the path. This lets a master overlap the next address with the tail of the current cycle.

The strobes and the status lines pass through a synchroniser into the slave clock domain. The block captures which cycle it owns, and whether that cycle is a read or a write, on the leading edge of the address latch strobe. If no address latch strobe was seen, it captures this on the leading edge of the command strobe instead. While status is active on a hit, the block holds channel-ready low. Once the address latch strobe has been seen, that low state is kept in a register.

How the hold is released depends on the mode:
- In synchronous mode, ready is released a fixed number of clocks after the command leading edge.
- In asynchronous mode, ready is released when the internal access signals completion.
- In either mode, a ceiling counter caps the hold.

Write data is captured when the command strobe ends. The read data drivers are enabled only while the owned read cycle still has status or command active.

Top module: `bus_slave_if`

## Requirements
- R1: `sfdbk_n` is low exactly when all of the following hold, and it follows address changes without waiting for a clock edge:
  - the address lies in [WIN_BASE, WIN_BASE+WIN_SPAN);
  - `bus_mem` equals WIN_MEM;
  - `bus_q24` equals WIN_Q24;
  - `bus_setup_n` is high.
- R2: On an address hit, `ds16_n` is low when PORT_BITS >= 16, and `ds32_n` is low when PORT_BITS >= 32. On a miss, both are high.
- R3: While `bus_setup_n` is low, `sfdbk_n` stays high. The slave is still selected, and a write cycle run under the setup line is captured.
- R4: The selection and the cycle direction are captured on the synchronised leading edge of `bus_ale_n`. A write cycle completes even if the address leaves the window after that edge.
- R5: Channel-ready (`chrdy`, high = ready) is low while the raw decode selects and status is active. Before the address latch strobe, it follows address changes combinationally. After the strobe, a registered hold keeps it low regardless of the address.
- R6: If status is deactivated without an address latch strobe (an abort), `chrdy` returns high with no clock delay. No write is captured and the drivers stay off.
- R7: In EXT_SYNC mode, the hold ends WAIT_TICKS clocks after the synchronised command leading edge. Counted from the clock after the command is driven, `chrdy` is sampled low SYNC_STAGES+WAIT_TICKS times.
- R8: In EXT_ASYNC mode, the hold ends on the clock edge that samples `acc_done` high.
- R9: The registered hold never lasts more than MAX_HOLD clocks. Counted from the clock after the address latch strobe is driven, `chrdy` is sampled low at most SYNC_STAGES+MAX_HOLD times.
- R10: On the synchronised trailing edge of the command in an owned write cycle, `wr_valid` pulses for one clock. In that clock, `wr_data` holds the bus data present while the command was active. Read cycles and cycles that are not owned never pulse `wr_valid`.
- R11: `drv_en` is high only during an owned read cycle while the synchronised status or command is active. `drv_data` equals `rd_data` when `drv_en` is high and is zero otherwise.
- R12: A cycle captured on the command strobe alone, without an address latch strobe, is not extended. `chrdy` goes high SYNC_STAGES+1 clocks after the command is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Bus address |
| bus_mem | input | 1 | 1 = memory space, 0 = IO space |
| bus_q24 | input | 1 | Above-16M address qualifier |
| bus_s0_n | input | 1 | Write status, active low |
| bus_s1_n | input | 1 | Read status, active low |
| bus_ale_n | input | 1 | Address latch strobe, active low |
| bus_cmd_n | input | 1 | Command strobe, active low |
| bus_setup_n | input | 1 | Card-setup select, active low |
| bus_wdata | input | DATA_W | Write data from the bus |
| sfdbk_n | output | 1 | Selected feedback, active low |
| ds16_n | output | 1 | 16-bit port reply, active low |
| ds32_n | output | 1 | 32-bit port reply, active low |
| chrdy | output | 1 | Channel ready, low extends the cycle |
| acc_done | input | 1 | Internal access complete (asynchronous release) |
| rd_data | input | DATA_W | Read data from the internal side |
| drv_en | output | 1 | Read data driver enable |
| drv_data | output | DATA_W | Gated read data toward the bus |
| wr_valid | output | 1 | One-clock write capture pulse |
| wr_data | output | DATA_W | Captured write data |

## Verification
The bench builds two instances on one shared bus, both with SYNC_STAGES=2:
- a 32-bit port in synchronous mode with WAIT_TICKS=4 and MAX_HOLD=30;
- a 16-bit port in asynchronous mode with MAX_HOLD=12.

The large ceiling on the first instance keeps its timed release clear of the cap, so the WAIT_TICKS count is measured on its own. On the second instance, the ceiling is small enough that a cycle left without completion reaches the cap within a few clocks. The two port widths cover both size reply patterns on the same address.

// File: rtl/bsi_pkg.sv
package bsi_pkg;

    typedef enum logic {
        EXT_SYNC  = 1'b0,
        EXT_ASYNC = 1'b1
    } ext_mode_e;

    // internal active-high view of the bus strobes
    typedef struct packed {
        logic ale;
        logic cmd;
        logic s0;
        logic s1;
    } strb_t;

    // owned-cycle record
    typedef struct packed {
        logic valid;
        logic write;
        logic read;
    } own_rec_t;

    function automatic logic in_window(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input logic [31:0] span);
        logic [32:0] lo;
        logic [32:0] hi;
        lo = {1'b0, base};
        hi = {1'b0, base} + {1'b0, span};
        return ({1'b0, a} >= lo) && ({1'b0, a} < hi);
    endfunction

endpackage

// File: rtl/bsi_sync.sv
module bsi_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= {st[STAGES-2:0], d};
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/bsi_decode.sv
module bsi_decode #(
    parameter int          ADDR_W    = 24,
    parameter logic [31:0] WIN_BASE  = 32'h0000_C000,
    parameter logic [31:0] WIN_SPAN  = 32'h0000_1000,
    parameter logic        WIN_MEM   = 1'b1,
    parameter logic        WIN_Q24   = 1'b0,
    parameter int          PORT_BITS = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem,
    input  logic              q24,
    input  logic              setup_n,
    output logic              hit,
    output logic              sel,
    output logic              sfdbk_n,
    output logic              ds16_n,
    output logic              ds32_n
);
    import bsi_pkg::*;

    logic sz16, sz32;

    assign hit = in_window(32'(addr), WIN_BASE, WIN_SPAN)
                 && (mem == WIN_MEM) && (q24 == WIN_Q24);
    assign sel = hit || !setup_n;
    assign sfdbk_n = !(hit && setup_n);

    if (PORT_BITS >= 16) begin : g_has16
        assign sz16 = hit;
    end else begin : g_no16
        assign sz16 = 1'b0;
    end

    if (PORT_BITS >= 32) begin : g_has32
        assign sz32 = hit;
    end else begin : g_no32
        assign sz32 = 1'b0;
    end

    assign ds16_n = !sz16;
    assign ds32_n = !sz32;
endmodule

// File: rtl/bsi_ready.sv
module bsi_ready
    import bsi_pkg::*;
#(
    parameter ext_mode_e EXT_MODE   = EXT_SYNC,
    parameter int        WAIT_TICKS = 4,
    parameter int        MAX_HOLD   = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic set_hold,
    input  logic end_cycle,
    input  logic cmd_rise,
    input  logic acc_done,
    output logic hold
);
    localparam int MW = $clog2(MAX_HOLD + 1);
    localparam int WW = $clog2(WAIT_TICKS + 1);
    localparam logic [MW-1:0] MLIM = MW'(MAX_HOLD - 1);
    localparam logic [WW-1:0] WLIM = WW'(WAIT_TICKS);

    logic [MW-1:0] mcnt;
    logic [WW-1:0] wcnt;
    logic          wrun;
    logic          tmr_done;
    logic          rel;

    assign tmr_done = wrun && (wcnt == WLIM);
    assign rel = (EXT_MODE == EXT_SYNC) ? tmr_done : acc_done;

    // timer started by the command leading edge
    always_ff @(posedge clk) begin
        if (rst || end_cycle || set_hold) begin
            wrun <= 1'b0;
            wcnt <= '0;
        end else if (cmd_rise && hold) begin
            wrun <= 1'b1;
            wcnt <= WW'(1);
        end else if (wrun && !tmr_done) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    // registered hold with ceiling
    always_ff @(posedge clk) begin
        if (rst || end_cycle) begin
            hold <= 1'b0;
            mcnt <= '0;
        end else if (set_hold) begin
            hold <= 1'b1;
            mcnt <= '0;
        end else if (hold) begin
            mcnt <= mcnt + 1'b1;
            if (rel || (mcnt == MLIM)) hold <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_slave_if.sv
module bus_slave_if
    import bsi_pkg::*;
#(
    parameter int          ADDR_W      = 24,
    parameter int          DATA_W      = 32,
    parameter logic [31:0] WIN_BASE    = 32'h0000_C000,
    parameter logic [31:0] WIN_SPAN    = 32'h0000_1000,
    parameter logic        WIN_MEM     = 1'b1,
    parameter logic        WIN_Q24     = 1'b0,
    parameter int          PORT_BITS   = 32,
    parameter int          SYNC_STAGES = 2,
    parameter ext_mode_e   EXT_MODE    = EXT_SYNC,
    parameter int          WAIT_TICKS  = 4,
    parameter int          MAX_HOLD    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_mem,
    input  logic              bus_q24,
    input  logic              bus_s0_n,
    input  logic              bus_s1_n,
    input  logic              bus_ale_n,
    input  logic              bus_cmd_n,
    input  logic              bus_setup_n,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              sfdbk_n,
    output logic              ds16_n,
    output logic              ds32_n,
    output logic              chrdy,
    input  logic              acc_done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              drv_en,
    output logic [DATA_W-1:0] drv_data,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data
);
    strb_t       strb_raw, strb_s;
    logic [3:0]  sync_q;
    logic        ale_d, cmd_d;
    logic        ale_rise, cmd_rise, cmd_fall;
    logic        stat_raw, stat_s, cmd_s;
    logic        hit, sel;
    own_rec_t    own_q;
    logic        lat_valid;
    logic        set_hold, end_cycle, hold, early_hold;
    logic [DATA_W-1:0] data_hold;

    // unlatched decode and replies
    bsi_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SPAN(WIN_SPAN),
        .WIN_MEM(WIN_MEM), .WIN_Q24(WIN_Q24), .PORT_BITS(PORT_BITS)
    ) u_dec (
        .addr(bus_addr), .mem(bus_mem), .q24(bus_q24), .setup_n(bus_setup_n),
        .hit(hit), .sel(sel), .sfdbk_n(sfdbk_n), .ds16_n(ds16_n), .ds32_n(ds32_n)
    );

    // strobe synchroniser
    assign strb_raw = '{ale: !bus_ale_n, cmd: !bus_cmd_n, s0: !bus_s0_n, s1: !bus_s1_n};

    bsi_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(strb_raw), .q(sync_q)
    );
    assign strb_s = strb_t'(sync_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_d <= 1'b0;
            cmd_d <= 1'b0;
        end else begin
            ale_d <= strb_s.ale;
            cmd_d <= strb_s.cmd;
        end
    end

    assign ale_rise = strb_s.ale && !ale_d;
    assign cmd_rise = strb_s.cmd && !cmd_d;
    assign cmd_fall = !strb_s.cmd && cmd_d;
    assign stat_raw = strb_raw.s0 || strb_raw.s1;
    assign stat_s   = strb_s.s0 || strb_s.s1;
    assign cmd_s    = strb_s.cmd;

    // owned-cycle capture: address latch strobe first, command as fallback
    assign end_cycle = own_q.valid && !stat_s && !cmd_s;

    always_ff @(posedge clk) begin
        if (rst || end_cycle) begin
            own_q <= '0;
        end else if (!own_q.valid && (ale_rise || cmd_rise) && sel) begin
            own_q.valid <= 1'b1;
            own_q.write <= strb_s.s0 && !strb_s.s1;
            own_q.read  <= strb_s.s1 && !strb_s.s0;
        end
    end
    assign lat_valid = own_q.valid;

    // ready: unlatched term before ownership, registered hold after the strobe
    assign set_hold   = !own_q.valid && ale_rise && sel && stat_s;
    assign early_hold = sel && stat_raw && !own_q.valid;

    bsi_ready #(
        .EXT_MODE(EXT_MODE), .WAIT_TICKS(WAIT_TICKS), .MAX_HOLD(MAX_HOLD)
    ) u_rdy (
        .clk(clk), .rst(rst), .set_hold(set_hold), .end_cycle(end_cycle),
        .cmd_rise(cmd_rise), .acc_done(acc_done), .hold(hold)
    );

    assign chrdy = !(early_hold || hold);

    // write capture at the command trailing edge
    always_ff @(posedge clk) begin
        if (rst) begin
            data_hold <= '0;
            wr_valid  <= 1'b0;
            wr_data   <= '0;
        end else begin
            if (cmd_s) data_hold <= bus_wdata;
            wr_valid <= cmd_fall && own_q.valid && own_q.write;
            if (cmd_fall && own_q.valid && own_q.write) wr_data <= data_hold;
        end
    end

    // read drivers
    assign drv_en   = own_q.valid && own_q.read && (stat_s || cmd_s);
    assign drv_data = drv_en ? rd_data : '0;
endmodule

// File: rtl/bus_slave_chk.sv
module bus_slave_chk #(
    parameter int MAX_HOLD = 16
) (
    input logic clk,
    input logic rst,
    input logic bus_s0_n,
    input logic bus_s1_n,
    input logic bus_setup_n,
    input logic sfdbk_n,
    input logic ds16_n,
    input logic ds32_n,
    input logic chrdy,
    input logic lat_valid,
    input logic hold,
    input logic ale_rise,
    input logic cmd_fall,
    input logic stat_s,
    input logic cmd_s,
    input logic drv_en,
    input logic wr_valid
);
    int hcnt;

    always_ff @(posedge clk) begin
        if (rst)       hcnt <= 0;
        else if (hold) hcnt <= hcnt + 1;
        else           hcnt <= 0;
    end

    p_size_nest_r2: assert property (@(posedge clk) disable iff (rst)
        !ds32_n |-> !ds16_n);

    p_setup_no_fb_r3: assert property (@(posedge clk) disable iff (rst)
        !bus_setup_n |-> sfdbk_n);

    p_hold_after_ale_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> $past(ale_rise));

    p_abort_release_r6: assert property (@(posedge clk) disable iff (rst)
        !chrdy |-> (!bus_s0_n || !bus_s1_n || lat_valid));

    p_hold_ceiling_r9: assert property (@(posedge clk) disable iff (rst)
        hcnt <= MAX_HOLD);

    p_wr_after_fall_r10: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(cmd_fall));

    p_drv_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!stat_s && !cmd_s) |-> !drv_en);
endmodule

bind bus_slave_if bus_slave_chk #(.MAX_HOLD(MAX_HOLD)) u_chk (
    .clk(clk), .rst(rst), .bus_s0_n(bus_s0_n), .bus_s1_n(bus_s1_n),
    .bus_setup_n(bus_setup_n), .sfdbk_n(sfdbk_n), .ds16_n(ds16_n),
    .ds32_n(ds32_n), .chrdy(chrdy), .lat_valid(lat_valid), .hold(hold),
    .ale_rise(ale_rise), .cmd_fall(cmd_fall), .stat_s(stat_s),
    .cmd_s(cmd_s), .drv_en(drv_en), .wr_valid(wr_valid)
);

// File: tb/bus_slave_if_tb_top.sv
`timescale 1ns/1ps
module bus_slave_if_tb_top;
    import bsi_pkg::*;

    localparam int S  = 2;
    localparam int WT = 4;
    localparam int MS = 30;
    localparam int MA = 12;
    localparam logic [23:0] BASE = 24'h00C000;
    localparam logic [23:0] SPAN = 24'h001000;
    localparam logic [23:0] MISS = 24'h000100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] bus_addr = MISS;
    logic        bus_mem = 1'b1, bus_q24 = 1'b0;
    logic        bus_s0_n = 1'b1, bus_s1_n = 1'b1;
    logic        bus_ale_n = 1'b1, bus_cmd_n = 1'b1, bus_setup_n = 1'b1;
    logic [31:0] bus_wdata = '0, rd_data = '0;
    logic        acc_i = 1'b0, acc_a = 1'b0;

    logic        sfdbk_i, ds16_i, ds32_i, chrdy_i, drv_en_i, wr_valid_i;
    logic [31:0] drv_data_i, wr_data_i;
    logic        sfdbk_a, ds16_a, ds32_a, chrdy_a, drv_en_a, wr_valid_a;
    logic [31:0] drv_data_a, wr_data_a;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [31:0] expq[$];

    always #4 clk = ~clk;

    bus_slave_if #(
        .PORT_BITS(32), .SYNC_STAGES(S), .EXT_MODE(EXT_SYNC),
        .WAIT_TICKS(WT), .MAX_HOLD(MS)
    ) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_mem(bus_mem), .bus_q24(bus_q24),
        .bus_s0_n(bus_s0_n), .bus_s1_n(bus_s1_n), .bus_ale_n(bus_ale_n),
        .bus_cmd_n(bus_cmd_n), .bus_setup_n(bus_setup_n), .bus_wdata(bus_wdata),
        .sfdbk_n(sfdbk_i), .ds16_n(ds16_i), .ds32_n(ds32_i), .chrdy(chrdy_i),
        .acc_done(acc_i), .rd_data(rd_data), .drv_en(drv_en_i), .drv_data(drv_data_i),
        .wr_valid(wr_valid_i), .wr_data(wr_data_i)
    );

    bus_slave_if #(
        .PORT_BITS(16), .SYNC_STAGES(S), .EXT_MODE(EXT_ASYNC),
        .WAIT_TICKS(WT), .MAX_HOLD(MA)
    ) dut_async_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_mem(bus_mem), .bus_q24(bus_q24),
        .bus_s0_n(bus_s0_n), .bus_s1_n(bus_s1_n), .bus_ale_n(bus_ale_n),
        .bus_cmd_n(bus_cmd_n), .bus_setup_n(bus_setup_n), .bus_wdata(bus_wdata),
        .sfdbk_n(sfdbk_a), .ds16_n(ds16_a), .ds32_n(ds32_a), .chrdy(chrdy_a),
        .acc_done(acc_a), .rd_data(rd_data), .drv_en(drv_en_a), .drv_data(drv_data_a),
        .wr_valid(wr_valid_a), .wr_data(wr_data_a)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_idle();
        bus_addr = MISS; bus_mem = 1'b1; bus_q24 = 1'b0;
        bus_s0_n = 1'b1; bus_s1_n = 1'b1; bus_ale_n = 1'b1;
        bus_cmd_n = 1'b1; bus_setup_n = 1'b1;
    endtask

    // scoreboard monitor: writes seen on dut_i are popped and compared
    always @(negedge clk) begin
        if (!rst && wr_valid_i) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R10 unexpected write", 64'(wr_data_i), 64'h0);
            end else begin
                logic [31:0] e;
                e = expq.pop_front();
                chk(wr_data_i == e, "R10 write data", 64'(wr_data_i), 64'(e));
            end
        end
    end

    // driver: one write cycle; expected item pushed when the slave owns it
    task automatic write_cycle(input logic [23:0] a, input logic [31:0] d,
                               input bit use_ale, input bit move_addr,
                               input bit expect_wr, input int exp_low,
                               input string req);
        int n;
        @(negedge clk);
        bus_addr = a; bus_s0_n = 1'b0;
        tick(1);
        if (use_ale) begin
            bus_ale_n = 1'b0;
            tick(2);
            bus_ale_n = 1'b1;
            tick(S + 2);
            if (move_addr) begin
                bus_addr = MISS;
                #1;
                chk(sfdbk_i == 1'b1, "R1 feedback follows moved address", 64'(sfdbk_i), 64'd1);
                chk(chrdy_i == 1'b0, "R5 latched hold survives address move", 64'(chrdy_i), 64'd0);
                @(negedge clk);
            end
        end
        bus_wdata = d; bus_cmd_n = 1'b0;
        n = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (chrdy_i) break;
            n++;
        end
        if (exp_low >= 0) chk(n == exp_low, req, 64'(n), 64'(exp_low));
        bus_s0_n = 1'b1;
        tick(1);
        bus_cmd_n = 1'b1;
        if (expect_wr) expq.push_back(d);
        tick(S + 4);
        bus_idle();
        tick(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 64'd0, 64'd1);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(3);
        // reset and idle state
        chk(chrdy_i == 1'b1, "R5 ready high after reset", 64'(chrdy_i), 64'd1);
        chk(drv_en_i == 1'b0, "R11 drivers off after reset", 64'(drv_en_i), 64'd0);
        chk(wr_valid_i == 1'b0, "R10 no write after reset", 64'(wr_valid_i), 64'd0);
        chk(sfdbk_i == 1'b1, "R1 no feedback on miss", 64'(sfdbk_i), 64'd1);

        // R1 / R2 combinational decode, no clock between changes
        bus_addr = BASE; #1;
        chk(sfdbk_i == 1'b0, "R1 hit at window base", 64'(sfdbk_i), 64'd0);
        chk({ds16_i, ds32_i} == 2'b00, "R2 32-bit port replies", 64'({ds16_i, ds32_i}), 64'd0);
        chk({ds16_a, ds32_a} == 2'b01, "R2 16-bit port replies", 64'({ds16_a, ds32_a}), 64'd1);
        bus_addr = BASE + SPAN - 1; #1;
        chk(sfdbk_i == 1'b0, "R1 hit at window top", 64'(sfdbk_i), 64'd0);
        bus_addr = BASE + SPAN; #1;
        chk({sfdbk_i, ds16_i, ds32_i} == 3'b111, "R1 miss past window", 64'({sfdbk_i, ds16_i, ds32_i}), 64'h7);
        bus_addr = BASE - 1; #1;
        chk(sfdbk_i == 1'b1, "R1 miss below window", 64'(sfdbk_i), 64'd1);
        bus_addr = BASE + 24'h10; bus_mem = 1'b0; #1;
        chk(sfdbk_i == 1'b1, "R1 IO space ignored", 64'(sfdbk_i), 64'd1);
        bus_mem = 1'b1; bus_q24 = 1'b1; #1;
        chk(sfdbk_i == 1'b1, "R1 qualifier mismatch", 64'(sfdbk_i), 64'd1);
        bus_q24 = 1'b0; bus_setup_n = 1'b0; #1;
        chk(sfdbk_i == 1'b1, "R3 no feedback under setup", 64'(sfdbk_i), 64'd1);
        chk(ds16_i == 1'b0, "R2 size reply on hit under setup", 64'(ds16_i), 64'd0);
        bus_idle();
        tick(2);

        // R5 / R6 abort without address latch strobe
        bus_addr = BASE; bus_s0_n = 1'b0; #1;
        chk(chrdy_i == 1'b0, "R5 unlatched ready low", 64'(chrdy_i), 64'd0);
        bus_addr = MISS; #1;
        chk(chrdy_i == 1'b1, "R5 unlatched ready follows address", 64'(chrdy_i), 64'd1);
        bus_addr = BASE; #1;
        chk(chrdy_i == 1'b0, "R5 unlatched ready low again", 64'(chrdy_i), 64'd0);
        tick(3);
        bus_s0_n = 1'b1; #1;
        chk(chrdy_i == 1'b1, "R6 release with status on abort", 64'(chrdy_i), 64'd1);
        tick(6);
        chk(chrdy_i == 1'b1 && drv_en_i == 1'b0, "R6 idle after abort",
            64'({chrdy_i, drv_en_i}), 64'h2);
        bus_idle();
        tick(2);

        // R7 / R4 / R10 write with address latch strobe and address moved
        write_cycle(BASE + 24'h20, 32'hDEAD_BEEF, 1, 1, 1, S + WT, "R7 sync extension length");
        write_cycle(BASE + 24'h24, 32'hFFFF_FFFF, 1, 0, 1, S + WT, "R7 sync extension repeat");
        write_cycle(BASE + 24'h28, 32'h0000_0000, 1, 0, 1, -1, "");
        // R12 command-only capture is not extended
        write_cycle(BASE + 24'h30, 32'hA5A5_5A5A, 0, 0, 1, S, "R12 no extension without strobe");
        // R3 setup-selected write captured
        bus_setup_n = 1'b0;
        write_cycle(MISS, 32'h1234_5678, 1, 0, 1, -1, "");
        // R1 missed write not captured and not extended
        write_cycle(MISS, 32'h0BAD_0BAD, 1, 0, 0, 0, "R1 miss is not extended");

        // R11 / R8 read cycle
        @(negedge clk);
        bus_addr = BASE + 24'h40; bus_s1_n = 1'b0; rd_data = 32'hCAFE_0001;
        tick(1);
        bus_ale_n = 1'b0;
        tick(2);
        bus_ale_n = 1'b1;
        tick(S + 2);
        chk(drv_en_i == 1'b1, "R11 drivers on in owned read", 64'(drv_en_i), 64'd1);
        chk(drv_data_i == 32'hCAFE_0001, "R11 read data passed", 64'(drv_data_i), 64'hCAFE0001);
        bus_cmd_n = 1'b0;
        tick(3);
        chk(chrdy_a == 1'b0, "R8 async held before completion", 64'(chrdy_a), 64'd0);
        acc_a = 1'b1; rd_data = 32'h0000_7777;
        tick(1);
        acc_a = 1'b0;
        chk(chrdy_a == 1'b1, "R8 async released on completion", 64'(chrdy_a), 64'd1);
        chk(drv_data_i == 32'h0000_7777, "R11 read data tracks source", 64'(drv_data_i), 64'h7777);
        for (int k = 0; k < 50; k++) begin
            if (chrdy_i) break;
            @(negedge clk);
        end
        bus_s1_n = 1'b1;
        tick(1);
        bus_cmd_n = 1'b1;
        tick(S + 1);
        chk(drv_en_i == 1'b0 && drv_data_i == 32'h0, "R11 drivers off after cycle",
            64'({drv_en_i, drv_data_i}), 64'h0);
        bus_idle();
        tick(4);

        // R9 ceiling on the async instance with no completion
        begin
            int n;
            @(negedge clk);
            bus_addr = BASE + 24'h50; bus_s0_n = 1'b0;
            tick(1);
            bus_ale_n = 1'b0;
            n = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (k == 1) bus_ale_n = 1'b1;
                if (chrdy_a) break;
                n++;
            end
            chk(n == S + MA, "R9 hold capped at ceiling", 64'(n), 64'(S + MA));
            bus_idle();
            tick(S + 3);
        end

        tick(10);
        chk(expq.size() == 0, "R10 all expected writes seen", 64'(expq.size()), 64'd0);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule